// File: doc/BRIEF.md
# Banked UART Register File

This block is the host-facing register file of a UART. A host reaches it through a 4-bit register address, an 8-bit write data bus and single-cycle read and write strobes. The address space is banked, and the current line-control value chooses the bank. When the top line-control bit is set, the two lowest addresses reach the baud divisor bytes. When line control holds the key value 0xBF, a hidden bank opens with the enhanced feature register and the four flow-control characters. Two mode bits, one in the enhanced feature register and one in modem control, swap modem status and scratch for the transmission-control and trigger-level registers.

The block stores every configuration register and drives each one out as a port for the serializers, FIFOs and flow-control logic next to it. Status values such as line status, modem status, interrupt identity, FIFO levels and GPIO pin states come in as inputs and are only multiplexed onto the read bus. Accesses to the data register are not stored here. They leave as strobes. Writes to the IO-control register can reset the whole file, and writes to FIFO control can emit one-cycle FIFO reset pulses.

Top module: `uart_bank_regfile`

## Requirements
- R1: After reset, line control reads 0x1D. Every other stored register is 0x00, and both FIFO reset pulses and both data strobes are low.
- R2: While line-control bit 7 is 1 and line control is not 0xBF, address 0 reaches the divisor low byte and address 1 reaches the divisor high byte. `dl_o` is {high, low}.
- R3: While line control equals 0xBF, these registers apply: address 2 is the enhanced feature register, addresses 4, 5, 6 and 7 are XON1, XON2, XOFF1 and XOFF2, and addresses 0 and 1 stay on the divisor. `flow_chars_o` is {XOFF2, XOFF1, XON2, XON1}.
- R4: While line control is not 0xBF, a read of address 2 returns `iir_i` and a write to address 2 goes to the FIFO control register.
- R5: Outside the 0xBF bank, addresses 6 and 7 reach transmission control and trigger level when enhanced bit 4 and modem-control bit 2 are both 1. Otherwise address 6 reads `msr_i` and address 7 is the scratch register.
- R6: While enhanced bit 4 is 0, a write leaves some bits at their old value: interrupt-enable bits 7:4, modem-control bits 7:5 and 2, and FIFO-control bits 5:4.
- R7: Some addresses are read-only: 5 returns `lsr_i`, 8 returns `tx_space_i`, 9 returns `rx_level_i`, and 6 returns `msr_i` while it maps to modem status. Writes to these addresses change no register. Address 0x0D reads as 0 and ignores writes.
- R8: Addresses 0x0A, 0x0C, 0x0E and 0x0F hold GPIO direction, GPIO interrupt enable, IO control and extra-feature control. A write to 0x0B sets `gpio_out_o`, and a read of 0x0B returns `gpio_i`. IO-control bit 2 always reads 0.
- R9: A write to 0x0E with bit 2 set returns every stored register to its reset value at that clock edge. The rest of that write's data is discarded.
- R10: A FIFO-control write with bit 1 (bit 2) set raises `rx_fifo_rst_o` (`tx_fifo_rst_o`) for exactly the cycle after the write edge. Bits 1 and 2 are never stored in `fcr_o`.
- R11: With line-control bit 7 at 0, a write to address 0 raises `thr_wr_o`, and a read raises `rhr_rd_o` and returns `rhr_i`, both in the same cycle. With bit 7 at 1, neither strobe rises.
- R12: A write to line control changes the decode from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from address |
| rhr_i | input | 8 | Head of receive FIFO |
| iir_i | input | 8 | Interrupt identity from interrupt logic |
| lsr_i | input | 8 | Line status |
| msr_i | input | 8 | Modem status |
| tx_space_i | input | 8 | Free transmit FIFO entries |
| rx_level_i | input | 8 | Filled receive FIFO entries |
| gpio_i | input | 8 | GPIO pin levels |
| thr_wr_o | output | 1 | Transmit data write strobe |
| rhr_rd_o | output | 1 | Receive data read strobe |
| dl_o | output | 16 | Baud divisor |
| lcr_o | output | 8 | Line control |
| ier_o | output | 8 | Interrupt enable |
| mcr_o | output | 8 | Modem control |
| fcr_o | output | 8 | FIFO control, pulse bits zero |
| efr_o | output | 8 | Enhanced features |
| flow_chars_o | output | 32 | {XOFF2, XOFF1, XON2, XON1} |
| tcr_o | output | 8 | Transmission control (flow thresholds) |
| tlr_o | output | 8 | Trigger levels |
| gpio_dir_o | output | 8 | GPIO direction |
| gpio_out_o | output | 8 | GPIO output values |
| gpio_ien_o | output | 8 | GPIO interrupt enable |
| ioc_o | output | 8 | IO control |
| efcr_o | output | 8 | Extra-feature control |
| rx_fifo_rst_o | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst_o | output | 1 | Transmit FIFO reset pulse |

## Verification
Read data and the two data strobes are combinational, so they are due in the same cycle as the access. The bench drives each access on a falling edge and samples it 1 ns later, before the next rising edge. Register contents and the FIFO reset pulses are due one rising edge after the write. The bench therefore samples them on the following falling edge, and a pulse is checked low again one cycle later. Bank changes are tested by a read issued on the access right after the line-control write, which is the first access the new decode must serve.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [DW-1:0] ENH_KEY      = 8'hBF;
  localparam logic [DW-1:0] IER_ENH_MASK = 8'hF0;
  localparam logic [DW-1:0] MCR_ENH_MASK = 8'hE4;
  localparam logic [DW-1:0] FCR_ENH_MASK = 8'h30;
  localparam logic [DW-1:0] FCR_PLS_MASK = 8'h06;
  localparam int IOC_SRST_BIT = 2;
  localparam int EFR_ENH_BIT  = 4;
  localparam int MCR_TCR_BIT  = 2;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_DATA, SEL_IER, SEL_DLL, SEL_DLH, SEL_IIR_FCR, SEL_EFR,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SPR, SEL_TCR, SEL_TLR,
    SEL_XON1, SEL_XON2, SEL_XOFF1, SEL_XOFF2, SEL_TXLVL, SEL_RXLVL,
    SEL_IODIR, SEL_IOSTATE, SEL_IOIEN, SEL_IOC, SEL_EFCR
  } sel_e;

  typedef struct packed {
    logic [DW-1:0] dll, dlh, lcr, ier, mcr, fcr, efr, spr;
    logic [DW-1:0] xon1, xon2, xoff1, xoff2, tcr, tlr;
    logic [DW-1:0] iodir, ioout, ioien, ioc, efcr;
  } cfg_t;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] lcr_i,
  input  logic          enh_i,
  input  logic          tcr_sel_i,
  output sel_e          sel_o
);
  logic dl_bank, key_bank, tcr_en;
  assign dl_bank  = lcr_i[DW-1];
  assign key_bank = (lcr_i == ENH_KEY);
  assign tcr_en   = enh_i && tcr_sel_i;

  always_comb begin
    sel_o = SEL_NONE;
    case (addr_i)
      4'h0: sel_o = dl_bank  ? SEL_DLL : SEL_DATA;
      4'h1: sel_o = dl_bank  ? SEL_DLH : SEL_IER;
      4'h2: sel_o = key_bank ? SEL_EFR : SEL_IIR_FCR;
      4'h3: sel_o = SEL_LCR;
      4'h4: sel_o = key_bank ? SEL_XON1 : SEL_MCR;
      4'h5: sel_o = key_bank ? SEL_XON2 : SEL_LSR;
      4'h6: sel_o = key_bank ? SEL_XOFF1 : (tcr_en ? SEL_TCR : SEL_MSR);
      4'h7: sel_o = key_bank ? SEL_XOFF2 : (tcr_en ? SEL_TLR : SEL_SPR);
      4'h8: sel_o = SEL_TXLVL;
      4'h9: sel_o = SEL_RXLVL;
      4'hA: sel_o = SEL_IODIR;
      4'hB: sel_o = SEL_IOSTATE;
      4'hC: sel_o = SEL_IOIEN;
      4'hE: sel_o = SEL_IOC;
      4'hF: sel_o = SEL_EFCR;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_rf_regs.sv
module uart_rf_regs
  import uart_rf_pkg::*;
#(
  parameter logic [DW-1:0] LCR_RST = 8'h1D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  sel_e          sel_i,
  input  logic [DW-1:0] wdata_i,
  output cfg_t          cfg_o,
  output logic          rx_rst_o,
  output logic          tx_rst_o
);
  localparam cfg_t CFG_RST = '{lcr: LCR_RST, default: '0};

  cfg_t cfg_q;
  logic rx_q, tx_q, enh, srst;

  assign enh  = cfg_q.efr[EFR_ENH_BIT];
  assign srst = wr_i && (sel_i == SEL_IOC) && wdata_i[IOC_SRST_BIT];

  // protected bits keep old value unless enhanced mode is on
  function automatic logic [DW-1:0] guard(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [DW-1:0] mask,
                                          input logic          open_v);
    return open_v ? new_v : ((new_v & ~mask) | (old_v & mask));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
      if (srst) begin
        cfg_q <= CFG_RST;
      end else if (wr_i) begin
        case (sel_i)
          SEL_DLL:     cfg_q.dll   <= wdata_i;
          SEL_DLH:     cfg_q.dlh   <= wdata_i;
          SEL_IER:     cfg_q.ier   <= guard(cfg_q.ier, wdata_i, IER_ENH_MASK, enh);
          SEL_IIR_FCR: begin
            cfg_q.fcr <= guard(cfg_q.fcr, wdata_i, FCR_ENH_MASK, enh) & ~FCR_PLS_MASK;
            rx_q      <= wdata_i[1];
            tx_q      <= wdata_i[2];
          end
          SEL_EFR:     cfg_q.efr   <= wdata_i;
          SEL_LCR:     cfg_q.lcr   <= wdata_i;
          SEL_MCR:     cfg_q.mcr   <= guard(cfg_q.mcr, wdata_i, MCR_ENH_MASK, enh);
          SEL_SPR:     cfg_q.spr   <= wdata_i;
          SEL_TCR:     cfg_q.tcr   <= wdata_i;
          SEL_TLR:     cfg_q.tlr   <= wdata_i;
          SEL_XON1:    cfg_q.xon1  <= wdata_i;
          SEL_XON2:    cfg_q.xon2  <= wdata_i;
          SEL_XOFF1:   cfg_q.xoff1 <= wdata_i;
          SEL_XOFF2:   cfg_q.xoff2 <= wdata_i;
          SEL_IODIR:   cfg_q.iodir <= wdata_i;
          SEL_IOSTATE: cfg_q.ioout <= wdata_i;
          SEL_IOIEN:   cfg_q.ioien <= wdata_i;
          SEL_IOC:     cfg_q.ioc   <= wdata_i;
          SEL_EFCR:    cfg_q.efcr  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign rx_rst_o = rx_q;
  assign tx_rst_o = tx_q;
endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
  import uart_rf_pkg::*;
#(
  parameter logic [7:0] LCR_RST = 8'h1D
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  rhr_i,
  input  logic [7:0]  iir_i,
  input  logic [7:0]  lsr_i,
  input  logic [7:0]  msr_i,
  input  logic [7:0]  tx_space_i,
  input  logic [7:0]  rx_level_i,
  input  logic [7:0]  gpio_i,
  output logic        thr_wr_o,
  output logic        rhr_rd_o,
  output logic [15:0] dl_o,
  output logic [7:0]  lcr_o,
  output logic [7:0]  ier_o,
  output logic [7:0]  mcr_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  efr_o,
  output logic [31:0] flow_chars_o,
  output logic [7:0]  tcr_o,
  output logic [7:0]  tlr_o,
  output logic [7:0]  gpio_dir_o,
  output logic [7:0]  gpio_out_o,
  output logic [7:0]  gpio_ien_o,
  output logic [7:0]  ioc_o,
  output logic [7:0]  efcr_o,
  output logic        rx_fifo_rst_o,
  output logic        tx_fifo_rst_o
);
  sel_e sel;
  cfg_t cfg;

  uart_rf_decode u_decode (
    .addr_i    (addr_i),
    .lcr_i     (cfg.lcr),
    .enh_i     (cfg.efr[EFR_ENH_BIT]),
    .tcr_sel_i (cfg.mcr[MCR_TCR_BIT]),
    .sel_o     (sel)
  );

  uart_rf_regs #(.LCR_RST(LCR_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg),
    .rx_rst_o (rx_fifo_rst_o),
    .tx_rst_o (tx_fifo_rst_o)
  );

  always_comb begin
    case (sel)
      SEL_DATA:    rdata_o = rhr_i;
      SEL_IER:     rdata_o = cfg.ier;
      SEL_DLL:     rdata_o = cfg.dll;
      SEL_DLH:     rdata_o = cfg.dlh;
      SEL_IIR_FCR: rdata_o = iir_i;
      SEL_EFR:     rdata_o = cfg.efr;
      SEL_LCR:     rdata_o = cfg.lcr;
      SEL_MCR:     rdata_o = cfg.mcr;
      SEL_LSR:     rdata_o = lsr_i;
      SEL_MSR:     rdata_o = msr_i;
      SEL_SPR:     rdata_o = cfg.spr;
      SEL_TCR:     rdata_o = cfg.tcr;
      SEL_TLR:     rdata_o = cfg.tlr;
      SEL_XON1:    rdata_o = cfg.xon1;
      SEL_XON2:    rdata_o = cfg.xon2;
      SEL_XOFF1:   rdata_o = cfg.xoff1;
      SEL_XOFF2:   rdata_o = cfg.xoff2;
      SEL_TXLVL:   rdata_o = tx_space_i;
      SEL_RXLVL:   rdata_o = rx_level_i;
      SEL_IODIR:   rdata_o = cfg.iodir;
      SEL_IOSTATE: rdata_o = gpio_i;
      SEL_IOIEN:   rdata_o = cfg.ioien;
      SEL_IOC:     rdata_o = cfg.ioc & ~(8'h1 << IOC_SRST_BIT);
      SEL_EFCR:    rdata_o = cfg.efcr;
      default:     rdata_o = '0;
    endcase
  end

  assign thr_wr_o     = wr_i && (sel == SEL_DATA);
  assign rhr_rd_o     = rd_i && (sel == SEL_DATA);
  assign dl_o         = {cfg.dlh, cfg.dll};
  assign lcr_o        = cfg.lcr;
  assign ier_o        = cfg.ier;
  assign mcr_o        = cfg.mcr;
  assign fcr_o        = cfg.fcr;
  assign efr_o        = cfg.efr;
  assign flow_chars_o = {cfg.xoff2, cfg.xoff1, cfg.xon2, cfg.xon1};
  assign tcr_o        = cfg.tcr;
  assign tlr_o        = cfg.tlr;
  assign gpio_dir_o   = cfg.iodir;
  assign gpio_out_o   = cfg.ioout;
  assign gpio_ien_o   = cfg.ioien;
  assign ioc_o        = cfg.ioc & ~(8'h1 << IOC_SRST_BIT);
  assign efcr_o       = cfg.efcr;
endmodule

// File: rtl/uart_bank_regfile_chk.sv
module uart_bank_regfile_chk #(
  parameter logic [7:0] LCR_RST = 8'h1D
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  rdata_o,
  input logic        thr_wr_o,
  input logic        rhr_rd_o,
  input logic [15:0] dl_o,
  input logic [7:0]  lcr_o,
  input logic [7:0]  ier_o,
  input logic [7:0]  mcr_o,
  input logic [7:0]  efr_o,
  input logic        rx_fifo_rst_o,
  input logic        tx_fifo_rst_o
);
  logic srst_wr;
  assign srst_wr = wr_i && (addr_i == 4'hE) && wdata_i[2];

  a_r11_thr_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_o |-> (wr_i && addr_i == 4'h0 && !lcr_o[7]));

  a_r11_rhr_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhr_rd_o |-> (rd_i && addr_i == 4'h0 && !lcr_o[7]));

  a_r10_rx_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fifo_rst_o |-> $past(wr_i && addr_i == 4'h2 && wdata_i[1] && lcr_o != 8'hBF));

  a_r10_tx_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fifo_rst_o |-> $past(wr_i && addr_i == 4'h2 && wdata_i[2] && lcr_o != 8'hBF));

  a_r6_ier_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!efr_o[4] && !srst_wr) |=> $stable(ier_o[7:4]));

  a_r6_mcr_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!efr_o[4] && !srst_wr) |=> ($stable(mcr_o[7:5]) && $stable(mcr_o[2])));

  a_r9_sw_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_wr |=> (lcr_o == LCR_RST && ier_o == 8'h00 && efr_o == 8'h00 && dl_o == 16'h0));

  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'hD) |-> rdata_o == 8'h00);

  a_r7_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == 4'h8 || addr_i == 4'h9 || addr_i == 4'hD))
      |=> ($stable(lcr_o) && $stable(dl_o) && $stable(ier_o) && $stable(mcr_o)));
endmodule

bind uart_bank_regfile uart_bank_regfile_chk #(.LCR_RST(LCR_RST)) u_chk (.*);

// File: tb/uart_bank_regfile_bench.sv
module uart_bank_regfile_bench;
  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 60;
  // write entries carry exp 0; reads compare rdata_o
  localparam vec_t TBL [NV] = '{
    '{1'b0,4'h3,8'h00,8'h1D,4'd1},  // R1 reset LCR
    '{1'b1,4'h3,8'h80,8'h00,4'd2},  // R2 divisor bank
    '{1'b1,4'h0,8'h34,8'h00,4'd2},
    '{1'b1,4'h1,8'h12,8'h00,4'd2},
    '{1'b0,4'h0,8'h00,8'h34,4'd2},
    '{1'b0,4'h1,8'h00,8'h12,4'd2},
    '{1'b1,4'h3,8'h03,8'h00,4'd12}, // R12 bank change
    '{1'b0,4'h1,8'h00,8'h00,4'd12},
    '{1'b1,4'h1,8'hFF,8'h00,4'd6},  // R6 IER guarded
    '{1'b0,4'h1,8'h00,8'h0F,4'd6},
    '{1'b0,4'h2,8'h00,8'hC1,4'd4},  // R4 IIR read
    '{1'b1,4'h2,8'hF9,8'h00,4'd4},
    '{1'b1,4'h4,8'hFF,8'h00,4'd6},
    '{1'b0,4'h4,8'h00,8'h1B,4'd6},
    '{1'b0,4'h6,8'h00,8'h30,4'd5},  // R5 MSR
    '{1'b1,4'h6,8'h77,8'h00,4'd7},  // R7 MSR write ignored
    '{1'b0,4'h6,8'h00,8'h30,4'd7},
    '{1'b1,4'h7,8'h66,8'h00,4'd5},
    '{1'b0,4'h7,8'h00,8'h66,4'd5},
    '{1'b1,4'h3,8'hBF,8'h00,4'd3},  // R3 key bank
    '{1'b1,4'h2,8'h10,8'h00,4'd3},
    '{1'b1,4'h4,8'h11,8'h00,4'd3},
    '{1'b1,4'h5,8'h13,8'h00,4'd3},
    '{1'b1,4'h6,8'h22,8'h00,4'd3},
    '{1'b1,4'h7,8'h33,8'h00,4'd3},
    '{1'b0,4'h2,8'h00,8'h10,4'd3},
    '{1'b0,4'h4,8'h00,8'h11,4'd3},
    '{1'b0,4'h5,8'h00,8'h13,4'd3},
    '{1'b0,4'h6,8'h00,8'h22,4'd3},
    '{1'b0,4'h7,8'h00,8'h33,4'd3},
    '{1'b0,4'h0,8'h00,8'h34,4'd3},
    '{1'b1,4'h3,8'h03,8'h00,4'd6},
    '{1'b1,4'h1,8'hF5,8'h00,4'd6},
    '{1'b0,4'h1,8'h00,8'hF5,4'd6},
    '{1'b1,4'h4,8'hFF,8'h00,4'd6},
    '{1'b0,4'h4,8'h00,8'hFF,4'd6},
    '{1'b1,4'h6,8'hE8,8'h00,4'd5},  // R5 TCR
    '{1'b0,4'h6,8'h00,8'hE8,4'd5},
    '{1'b1,4'h7,8'h4C,8'h00,4'd5},
    '{1'b0,4'h7,8'h00,8'h4C,4'd5},
    '{1'b0,4'h5,8'h00,8'h60,4'd7},  // R7 read-only
    '{1'b1,4'h5,8'hFF,8'h00,4'd7},
    '{1'b0,4'h5,8'h00,8'h60,4'd7},
    '{1'b0,4'h8,8'h00,8'h40,4'd7},
    '{1'b0,4'h9,8'h00,8'h03,4'd7},
    '{1'b1,4'h9,8'hFF,8'h00,4'd7},
    '{1'b0,4'h9,8'h00,8'h03,4'd7},
    '{1'b0,4'hD,8'h00,8'h00,4'd7},
    '{1'b1,4'hD,8'hFF,8'h00,4'd7},
    '{1'b0,4'hD,8'h00,8'h00,4'd7},
    '{1'b1,4'hA,8'h0F,8'h00,4'd8},  // R8 GPIO
    '{1'b0,4'hA,8'h00,8'h0F,4'd8},
    '{1'b1,4'hB,8'h3C,8'h00,4'd8},
    '{1'b0,4'hB,8'h00,8'hA5,4'd8},
    '{1'b1,4'hC,8'h81,8'h00,4'd8},
    '{1'b0,4'hC,8'h00,8'h81,4'd8},
    '{1'b1,4'hE,8'h03,8'h00,4'd8},
    '{1'b0,4'hE,8'h00,8'h03,4'd8},
    '{1'b1,4'hF,8'h96,8'h00,4'd8},
    '{1'b0,4'hF,8'h00,8'h96,4'd8}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic thr_wr_o, rhr_rd_o, rx_fifo_rst_o, tx_fifo_rst_o;
  logic [15:0] dl_o;
  logic [31:0] flow_chars_o;
  logic [7:0] lcr_o, ier_o, mcr_o, fcr_o, efr_o, tcr_o, tlr_o;
  logic [7:0] gpio_dir_o, gpio_out_o, gpio_ien_o, ioc_o, efcr_o;
  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  uart_bank_regfile u_uart_bank_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .rhr_i(8'h5A), .iir_i(8'hC1), .lsr_i(8'h60), .msr_i(8'h30),
    .tx_space_i(8'h40), .rx_level_i(8'h03), .gpio_i(8'hA5),
    .thr_wr_o(thr_wr_o), .rhr_rd_o(rhr_rd_o), .dl_o(dl_o), .lcr_o(lcr_o),
    .ier_o(ier_o), .mcr_o(mcr_o), .fcr_o(fcr_o), .efr_o(efr_o),
    .flow_chars_o(flow_chars_o), .tcr_o(tcr_o), .tlr_o(tlr_o),
    .gpio_dir_o(gpio_dir_o), .gpio_out_o(gpio_out_o), .gpio_ien_o(gpio_ien_o),
    .ioc_o(ioc_o), .efcr_o(efcr_o),
    .rx_fifo_rst_o(rx_fifo_rst_o), .tx_fifo_rst_o(tx_fifo_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge; write lands on next rising edge
  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; rd_i = 1'b0; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", {24'h0, lcr_o}, 32'h1D);
    chk("R1", {16'h0, dl_o}, 32'h0);
    chk("R1", {ier_o, mcr_o, efr_o, fcr_o}, 32'h0);
    chk("R1", {28'h0, rx_fifo_rst_o, tx_fifo_rst_o, thr_wr_o, rhr_rd_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_i = TBL[i].wr; rd_i = !TBL[i].wr;
      addr_i = TBL[i].addr; wdata_i = TBL[i].data;
      #1;
      if (!TBL[i].wr) chk($sformatf("R%0d vec %0d", TBL[i].req, i), {24'h0, rdata_o}, {24'h0, TBL[i].exp});
    end
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;

    chk("R2", {16'h0, dl_o}, 32'h1234);
    chk("R3", flow_chars_o, 32'h33221311);
    chk("R5", {16'h0, tcr_o, tlr_o}, 32'hE84C);
    chk("R6", {24'h0, fcr_o}, 32'hC9);
    chk("R6", {16'h0, ier_o, mcr_o}, 32'hF5FF);
    chk("R8", {gpio_dir_o, gpio_out_o, gpio_ien_o, efcr_o}, 32'h0F3C8196);
    chk("R8", {24'h0, ioc_o}, 32'h03);

    // R10 FIFO reset pulses
    do_write(4'h2, 8'h36);
    chk("R10", {30'h0, rx_fifo_rst_o, tx_fifo_rst_o}, 32'h3);
    chk("R10", {24'h0, fcr_o}, 32'h30);
    @(negedge clk_i);
    chk("R10", {30'h0, rx_fifo_rst_o, tx_fifo_rst_o}, 32'h0);
    do_write(4'h2, 8'h32);
    chk("R10", {30'h0, rx_fifo_rst_o, tx_fifo_rst_o}, 32'h2);

    // R11 data strobes
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 4'h0; wdata_i = 8'h41;
    #1 chk("R11", {31'h0, thr_wr_o}, 32'h1);
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b1;
    #1 chk("R11", {23'h0, rhr_rd_o, rdata_o}, {23'h0, 1'b1, 8'h5A});
    @(negedge clk_i);
    rd_i = 1'b0;
    do_write(4'h3, 8'h83);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 4'h0; wdata_i = 8'h77;
    #1 chk("R11", {31'h0, thr_wr_o}, 32'h0);
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b1;
    #1 chk("R11", {31'h0, rhr_rd_o}, 32'h0);
    @(negedge clk_i);
    rd_i = 1'b0;

    // R6 guard with enhanced mode off
    do_write(4'h3, 8'hBF);
    do_write(4'h2, 8'h00);
    do_write(4'h3, 8'h03);
    do_write(4'h1, 8'h00);
    chk("R6", {24'h0, ier_o}, 32'hF0);
    do_write(4'h4, 8'h00);
    chk("R6", {24'h0, mcr_o}, 32'hE4);

    // R9 software reset
    do_write(4'hE, 8'h07);
    chk("R9", {lcr_o, ier_o, efr_o, ioc_o}, 32'h1D000000);
    chk("R9", {dl_o, gpio_out_o, fcr_o}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule